// File: doc/BRIEF.md
# Sync-Qualified Slot Response Scheduler

This block sits between a digitised sync-comparator level and a serial frame transmitter. It qualifies sync pulses by counting consecutive clocks at which the comparator is high. The clock at which a pulse qualifies is the trigger. After the trigger, the block counts ticks of a 2 MHz enable, so one count is 0.5 µs. It tells the transmitter when to take a sample and when to start a frame, for up to two programmable slots.

The block also tracks a continuous sample stream that comes with a valid strobe. When the mode asks for a latch, it captures the newest valid sample. The mode, both slot offsets and the slot-B admission decision are captured at the trigger. Later changes on those inputs do not affect a response that is already scheduled.

The block ignores any new sync from the trigger until the transmitter reports completion after the last start of that response.

Top module: `sync_slot_scheduler`

## Requirements
- R1: A sync is accepted at the clock edge where `sync_cmp_i` has been sampled high on QUAL_LIM+1 consecutive edges, counting that edge. That edge is the trigger. A high run of QUAL_LIM edges or fewer produces no response.
- R2: A low sample on `sync_cmp_i` clears the qualification count. Two runs of QUAL_LIM high edges, separated by one low edge, produce no response.
- R3: `start_o` is a one-clock pulse. The slot-A start edge is the first edge at which the number of `tick_i` pulses, counted on edges strictly after the trigger and before that edge, equals the 10-bit `slot_a_i`. Slot B is timed the same way from `slot_b_i`. `slot_o` reads 0 for slot A and 1 for slot B and holds between starts.
- R4: With mode 2'b00 (trigger latch), `smp_o` at the slot-A start holds the newest sample at the trigger edge.
- R5: With mode 2'b01 (slot latch), `smp_o` at the slot-A start holds the newest sample at the slot-A start edge.
- R6: With mode 2'b10 (double rate), slot A behaves as in R5. A slot-B start follows, and `smp_o` at that start holds the newest sample at the slot-B start edge.
- R7: With mode 2'b11 (split word), the sample is taken at the trigger. It is presented at the slot-A start and again, unchanged, at the slot-B start.
- R8: In modes 2'b00 and 2'b01 there is never a slot-B start.
- R9: Slot B is sent only if `slot_b_i` >= `slot_a_i` + FRAME_TICKS at the trigger. Otherwise slot B is suppressed and only slot A is sent.
- R10: While a response is pending, or its last start has been issued but `tx_done_i` has not yet come, a qualifying sync has no effect: no restart and no extra start. A `tx_done_i` that arrives while a start is still pending is ignored.
- R11: The newest sample is the last `smp_data_i` seen with `smp_vld_i` high. If `smp_vld_i` is low at a latch edge, the previous valid value is taken.
- R12: After reset, `start_o`, `slot_o` and `smp_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 2 MHz enable, one slot count per pulse |
| sync_cmp_i | input | 1 | Digitised sync comparator level |
| smp_data_i | input | SMP_W | Sample stream data |
| smp_vld_i | input | 1 | Sample stream valid strobe |
| mode_i | input | 2 | 00 trigger latch, 01 slot latch, 10 double rate, 11 split word |
| slot_a_i | input | SLOT_W | Slot A offset in ticks from the trigger |
| slot_b_i | input | SLOT_W | Slot B offset in ticks from the trigger |
| tx_done_i | input | 1 | Transmitter finished the current response |
| smp_o | output | SMP_W | Latched sample for the transmitter |
| start_o | output | 1 | Start-of-frame pulse |
| slot_o | output | 1 | Identity of the last started slot |

## Verification
The bench sweeps every mode against slot-B offsets one tick inside and exactly at the conflict boundary. A design with an off-by-one conflict compare would either drop a legal slot-B start or emit a colliding one.

Several further corner cases are covered:
- Qualification runs are one edge short and split by a single low sample. A design that fired one edge early, or that did not clear the count on a low sample, would produce a start.
- Slot offsets of 0 and 1023 are tested, with the tick running at half rate. This exposes a timer that counts the trigger tick or wraps.
- A sync arrives in mid-response and a done arrives early. A design that restarted its timer would show a shifted start, and one that released early would lose slot B.
- The valid strobe is dropped on the latch edge. This catches a latch that takes the raw stream instead of the last valid sample.

// File: rtl/sts_pkg.sv
package sts_pkg;

  typedef enum logic [1:0] {
    MODE_TRIG  = 2'b00,
    MODE_SLOT  = 2'b01,
    MODE_DUAL  = 2'b10,
    MODE_SPLIT = 2'b11
  } smode_e;

  // sample is captured at the trigger rather than at slot A
  function automatic logic lat_at_trig(smode_e m);
    return (m == MODE_TRIG) || (m == MODE_SPLIT);
  endfunction

endpackage

// File: rtl/sts_sync_qual.sv
module sts_sync_qual #(
  parameter int QUAL_LIM = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_i,
  output logic acc_o
);
  localparam int QW = $clog2(QUAL_LIM + 2);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                              cnt_q <= '0;
    else if (!cmp_i)                      cnt_q <= '0;
    else if (cnt_q != QW'(QUAL_LIM + 1))  cnt_q <= cnt_q + 1'b1;
  end

  // qualifies once per high run, on the edge that pushes the count past the limit
  assign acc_o = cmp_i && (cnt_q == QW'(QUAL_LIM));

  a_r1_high_before_acc: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> $past(cmp_i));
  a_r2_one_acc_per_run: assert property (@(posedge clk) disable iff (rst)
    acc_o |=> !acc_o);

endmodule

// File: rtl/sts_smp_latch.sv
module sts_smp_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] data_i,
  input  logic         vld_i,
  input  logic         lat_i,
  output logic [W-1:0] smp_o
);
  logic [W-1:0] hold_q;
  logic [W-1:0] newest;
  logic [W-1:0] smp_q;

  assign newest = vld_i ? data_i : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      smp_q  <= '0;
    end else begin
      if (vld_i) hold_q <= data_i;
      if (lat_i) smp_q  <= newest;
    end
  end

  assign smp_o = smp_q;

  a_r11_hold_without_latch: assert property (@(posedge clk) disable iff (rst)
    !lat_i |=> $stable(smp_o));
  a_r11_takes_valid_data: assert property (@(posedge clk) disable iff (rst)
    (lat_i && vld_i) |=> (smp_o == $past(data_i)));

endmodule

// File: rtl/sts_slot_ctrl.sv
module sts_slot_ctrl
  import sts_pkg::*;
#(
  parameter int SLOT_W      = 10,
  parameter int FRAME_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              acc_i,
  input  logic [1:0]        mode_i,
  input  logic [SLOT_W-1:0] slot_a_i,
  input  logic [SLOT_W-1:0] slot_b_i,
  input  logic              tx_done_i,
  output logic              lat_o,
  output logic              start_o,
  output logic              slot_o
);
  localparam int CW = SLOT_W + $clog2(FRAME_TICKS + 1) + 1;

  smode_e            mode_q;
  logic [SLOT_W-1:0] sa_q, sb_q, tmr_q;
  logic              busy_q, pa_q, pb_q, start_q, slot_q;
  logic              take, fire_a, fire_b, b_ok;
  smode_e            mode_in;

  assign mode_in = smode_e'(mode_i);
  assign take    = acc_i && !busy_q;
  assign fire_a  = pa_q && (tmr_q == sa_q);
  assign fire_b  = pb_q && !pa_q && (tmr_q == sb_q);
  assign b_ok    = mode_i[1] &&
                   (CW'(slot_b_i) >= CW'(slot_a_i) + CW'(FRAME_TICKS));

  assign lat_o = (take && lat_at_trig(mode_in)) ||
                 (fire_a && !lat_at_trig(mode_q)) ||
                 (fire_b && (mode_q == MODE_DUAL));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      pa_q    <= 1'b0;
      pb_q    <= 1'b0;
      tmr_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      mode_q  <= MODE_TRIG;
      start_q <= 1'b0;
      slot_q  <= 1'b0;
    end else begin
      start_q <= fire_a || fire_b;
      if (fire_a)      slot_q <= 1'b0;
      else if (fire_b) slot_q <= 1'b1;
      if (take) begin
        busy_q <= 1'b1;
        pa_q   <= 1'b1;
        pb_q   <= b_ok;
        tmr_q  <= '0;
        sa_q   <= slot_a_i;
        sb_q   <= slot_b_i;
        mode_q <= mode_in;
      end else begin
        if ((pa_q || pb_q) && tick_i && (tmr_q != {SLOT_W{1'b1}}))
          tmr_q <= tmr_q + 1'b1;
        if (fire_a) pa_q <= 1'b0;
        if (fire_b) pb_q <= 1'b0;
        if (busy_q && !pa_q && !pb_q && tx_done_i)
          busy_q <= 1'b0;
      end
    end
  end

  assign start_o = start_q;
  assign slot_o  = slot_q;

  a_r3_start_is_pulse: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  a_r10_start_only_busy: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(busy_q));
  a_r8_slot_b_needs_mode: assert property (@(posedge clk) disable iff (rst)
    (start_o && slot_o) |-> mode_q[1]);
  a_r9_slot_b_spacing: assert property (@(posedge clk) disable iff (rst)
    (start_o && slot_o) |-> (CW'(sb_q) >= CW'(sa_q) + CW'(FRAME_TICKS)));
  a_r10_busy_keeps_config: assert property (@(posedge clk) disable iff (rst)
    (acc_i && busy_q) |=> ($stable(sa_q) && $stable(sb_q) && $stable(mode_q)));

endmodule

// File: rtl/sync_slot_scheduler.sv
module sync_slot_scheduler #(
  parameter int SMP_W       = 16,
  parameter int SLOT_W      = 10,
  parameter int QUAL_LIM    = 4,
  parameter int FRAME_TICKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              sync_cmp_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  input  logic              smp_vld_i,
  input  logic [1:0]        mode_i,
  input  logic [SLOT_W-1:0] slot_a_i,
  input  logic [SLOT_W-1:0] slot_b_i,
  input  logic              tx_done_i,
  output logic [SMP_W-1:0]  smp_o,
  output logic              start_o,
  output logic              slot_o
);
  logic acc;
  logic lat;

  sts_sync_qual #(.QUAL_LIM(QUAL_LIM)) u_qual (
    .clk   (clk),
    .rst   (rst),
    .cmp_i (sync_cmp_i),
    .acc_o (acc)
  );

  sts_slot_ctrl #(.SLOT_W(SLOT_W), .FRAME_TICKS(FRAME_TICKS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .acc_i     (acc),
    .mode_i    (mode_i),
    .slot_a_i  (slot_a_i),
    .slot_b_i  (slot_b_i),
    .tx_done_i (tx_done_i),
    .lat_o     (lat),
    .start_o   (start_o),
    .slot_o    (slot_o)
  );

  sts_smp_latch #(.W(SMP_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .data_i (smp_data_i),
    .vld_i  (smp_vld_i),
    .lat_i  (lat),
    .smp_o  (smp_o)
  );

endmodule

// File: tb/sync_slot_scheduler_tb_top.sv
module sync_slot_scheduler_tb_top;
  localparam int SMP_W = 16, SLOT_W = 10, LIM = 4, FRAME = 8;

  logic clk = 1'b0, rst = 1'b1, tick_i = 1'b0, sync_cmp_i = 1'b0;
  logic [SMP_W-1:0]  smp_data_i = '0;
  logic              smp_vld_i  = 1'b0;
  logic [1:0]        mode_i     = 2'b00;
  logic [SLOT_W-1:0] slot_a_i   = '0, slot_b_i = '0;
  logic              tx_done_i  = 1'b0;
  logic [SMP_W-1:0]  smp_o;
  logic              start_o, slot_o;

  int vectors = 0, fails = 0, ec = 0;
  bit finished = 0;
  logic [SMP_W-1:0] lastv = '0, edge_newest = '0;

  always #2 clk = ~clk;

  sync_slot_scheduler #(.SMP_W(SMP_W), .SLOT_W(SLOT_W), .QUAL_LIM(LIM),
                        .FRAME_TICKS(FRAME)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SMP_W-1:0] dval(input int n);
    return SMP_W'(16'h5000 + n * 3);
  endfunction

  // apply inputs for one edge, then wait until the following falling edge
  task automatic step(input bit tk, input bit vld);
    tick_i     = tk;
    smp_vld_i  = vld;
    smp_data_i = dval(ec);
    if (vld) lastv = dval(ec);
    edge_newest = lastv;
    @(negedge clk);
    ec++;
  endtask

  task automatic quiet(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(ec[0], 1'b1);
      chk(start_o == 1'b0, tag, start_o, 0);
    end
  endtask

  task automatic trial(input logic [1:0] m, input int sa, input int sb,
                       input bit resync, input bit early_done, input bit novld);
    logic [SMP_W-1:0] acc_val;
    bit pa, pb, ea, eb, prev_a;
    int k, pre, lim, j;
    logic tk;
    mode_i = m; slot_a_i = SLOT_W'(sa); slot_b_i = SLOT_W'(sb);
    sync_cmp_i = 1'b1;
    for (int i = 0; i <= LIM; i++) begin
      step(ec[0], !(novld && i == LIM));
      chk(start_o == 1'b0, "R1 no start during qualification", start_o, 0);
    end
    acc_val = edge_newest;
    sync_cmp_i = 1'b0;
    // slot-B admission per R9
    pa = 1; pb = m[1] && (sb >= sa + FRAME);
    k = 0; j = 0; prev_a = 0;
    lim = 2 * ((sa > sb) ? sa : sb) + 2 * FRAME + 20;
    while ((pa || pb) && j < lim) begin
      if (resync) sync_cmp_i = (j >= 1 && j <= LIM + 3);
      tx_done_i = early_done && prev_a;
      pre = k; tk = ec[0];
      ea = pa && (pre == sa);
      eb = !ea && pb && !pa && (pre == sb);
      step(tk, 1'b1);
      k += int'(tk);
      chk(start_o == (ea || eb), resync ? "R10 start timing under resync" :
          "R3 start timing", start_o, ea || eb);
      prev_a = ea;
      if (ea) begin
        chk(slot_o == 1'b0, "R3 slot id A", slot_o, 0);
        if (m == 2'b00 || m == 2'b11)
          chk(smp_o == acc_val, novld ? "R11 held sample" :
              (m == 2'b00 ? "R4 trigger latch" : "R7 split latch A"), smp_o, acc_val);
        else
          chk(smp_o == edge_newest, "R5 slot A latch", smp_o, edge_newest);
        pa = 0;
      end
      if (eb) begin
        chk(slot_o == 1'b1, "R3 slot id B", slot_o, 1);
        if (m == 2'b10)
          chk(smp_o == edge_newest, "R6 slot B latch", smp_o, edge_newest);
        else
          chk(smp_o == acc_val, "R7 split latch B", smp_o, acc_val);
        pb = 0;
      end
      j++;
    end
    tx_done_i = 1'b0;
    sync_cmp_i = 1'b0;
    chk(!(pa || pb), "R3 missing start", {30'd0, pa, pb}, 0);
    // sync while busy after last start must be ignored, and no stray slot B
    sync_cmp_i = 1'b1;
    quiet(LIM + 2, !m[1] ? "R8 no slot B" : "R10 busy ignores sync");
    sync_cmp_i = 1'b0;
    quiet(2 * FRAME + 4, m[1] ? "R9 no suppressed slot B" : "R8 no slot B");
    tx_done_i = 1'b1;
    step(ec[0], 1'b1);
    tx_done_i = 1'b0;
    step(ec[0], 1'b1);
    step(ec[0], 1'b1);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk(start_o == 1'b0, "R12 reset start", start_o, 0);
    chk(slot_o == 1'b0, "R12 reset slot", slot_o, 0);
    chk(smp_o == '0, "R12 reset sample", smp_o, 0);

    // R1 and R2: short run, gap of one low edge, short run again
    mode_i = 2'b00; slot_a_i = '0; slot_b_i = '0;
    sync_cmp_i = 1'b1;
    for (int i = 0; i < LIM; i++) step(ec[0], 1'b1);
    sync_cmp_i = 1'b0;
    step(ec[0], 1'b1);
    sync_cmp_i = 1'b1;
    for (int i = 0; i < LIM; i++) begin
      step(ec[0], 1'b1);
      chk(start_o == 1'b0, "R2 count cleared by low", start_o, 0);
    end
    sync_cmp_i = 1'b0;
    quiet(20, "R1 short pulse ignored");

    trial(2'b00, 5, 30, 0, 0, 0);
    trial(2'b01, 5, 30, 0, 0, 0);
    trial(2'b10, 5, 20, 0, 1, 0);
    trial(2'b11, 6, 14, 0, 0, 0);
    trial(2'b10, 6, 13, 0, 0, 0);
    trial(2'b10, 10, 3, 0, 0, 0);
    trial(2'b00, 0, 0, 0, 0, 0);
    trial(2'b01, 1023, 0, 0, 0, 0);
    trial(2'b10, 3, 1023, 0, 0, 0);
    trial(2'b00, 12, 40, 1, 0, 0);
    trial(2'b10, 12, 40, 1, 1, 0);
    trial(2'b00, 4, 9, 0, 0, 1);
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 4; a++)
        for (int d = -1; d <= 0; d++)
          trial(2'(m), (a == 3) ? 7 : a, ((a == 3) ? 7 : a) + FRAME + d, 0, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule